// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block is a SPI master for a multichannel successive-approximation converter that is run in manual channel-select mode. A one-cycle start pulse, together with a channel enable mask, begins a scan. The block then sends one 16-bit command frame for each enabled channel, lowest index first. Two trailing flush frames follow, because the converter returns each result two frames after the command that asked for it.

Each response word carries the channel number in its upper nibble. The block matches every returned word to the command that requested it and compares that nibble with the expected channel. It then extracts the left-aligned sample below the nibble. The result goes out as a one-cycle valid pulse with the sample, the channel number and a mismatch flag. A scan of a single channel is three frames long.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is held and directly after it is released, cs_n is 1, sclk is 0, busy is 0 and res_valid is 0.
- R2: Each command word is shifted out MSB first. It has bit 12 = 1 (manual select), bit 11 = 1 (settings write), bits 10:7 = channel number and bit 6 = the RANGE_DBL parameter. All other bits are 0.
- R3: A scan with N enabled channels sends exactly N+2 frames. The first N frames address the enabled channels in ascending index order, one frame each.
- R4: The two trailing flush frames repeat the last channel command word unchanged.
- R5: The response shifted in during frame k+2 belongs to the command of frame k. The responses of the first two frames of a scan are discarded. Each enabled channel produces exactly one res_valid pulse, in scan order, with res_chan equal to the channel and res_data equal to response bits 11 down to 12-SAMPLE_W.
- R6: res_err is 1 on a result exactly when response bits 15:12 differ from the expected channel. The sample is still delivered in that case. res_err is 0 whenever res_valid is 0.
- R7: busy rises on the clock edge after an accepted start and falls one cycle after the last result pulse. A start while busy is ignored, and so is a start with an all-zero mask.
- R8: The SPI link uses mode 0. sclk is low whenever cs_n is high, and each sclk level lasts CLK_DIV clocks. MOSI does not change while sclk is high. cs_n stays high for at least 2*CLK_DIV clocks between frames.
- R9: A mask with a single bit set produces exactly three frames and one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle scan request |
| ch_mask | input | NUM_CH | Enabled channels, sampled with start |
| busy | output | 1 | Scan in progress |
| sclk | output | 1 | SPI serial clock, idle low |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Command data to converter |
| miso | input | 1 | Response data from converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | SAMPLE_W | Extracted sample |
| res_chan | output | 4 | Channel the result belongs to |
| res_err | output | 1 | Tag mismatch on this result |

## Verification
The hardest condition to reach from the ports is a tag mismatch, because a well-behaved converter always echoes the channel it was asked for. The bench converter model keeps the two-frame response history itself. It can be told to corrupt the tag nibble for one chosen channel, so that a bad tag lands between good ones in the middle of a scan. Tag corruption is also enabled on some of the random masks. Separately, a second start arriving mid-scan with a different mask shows that the first scan's frame list is left untouched.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   localparam int FRAME_W    = 16;
   localparam int TAG_MSB    = 15;
   localparam int TAG_LSB    = 12;
   localparam int SAMPLE_MSB = 11;
   localparam int RESP_LAT   = 2;   // frames between a command and its answer

   typedef logic [FRAME_W-1:0] frame_t;
   typedef logic [3:0]         chan_t;

   // command word: manual select, settings write, channel, range doubling
   function automatic frame_t mk_cmd(input chan_t ch, input logic dbl);
      frame_t w;
      w       = '0;
      w[12]   = 1'b1;
      w[11]   = 1'b1;
      w[10:7] = ch;
      w[6]    = dbl;
      return w;
   endfunction

endpackage

// File: rtl/adc_spi_frame.sv
// One 16-bit mode-0 transfer followed by a deselect gap.
module adc_spi_frame
   import adc_scan_pkg::*;
#(
   parameter int CLK_DIV = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   go,
   input  frame_t tx_word,
   output frame_t rx_word,
   output logic   done,
   output logic   sclk,
   output logic   cs_n,
   output logic   mosi,
   input  logic   miso
);

   localparam int DIV_W = $clog2(2*CLK_DIV + 1);
   localparam int BIT_W = $clog2(FRAME_W);

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
   endgenerate

   typedef enum logic [1:0] {F_IDLE, F_SHIFT, F_GAP} fstate_t;

   fstate_t          st;
   logic [DIV_W-1:0] div_cnt;
   logic [BIT_W-1:0] bit_cnt;
   frame_t           sh_tx;
   frame_t           sh_rx;
   logic             sclk_q;
   logic             cs_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= F_IDLE;
         div_cnt <= '0;
         bit_cnt <= '0;
         sh_tx   <= '0;
         sh_rx   <= '0;
         sclk_q  <= 1'b0;
         cs_q    <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st)
            F_IDLE: begin
               if (go) begin
                  sh_tx   <= tx_word;
                  cs_q    <= 1'b0;
                  sclk_q  <= 1'b0;
                  div_cnt <= '0;
                  bit_cnt <= '0;
                  st      <= F_SHIFT;
               end
            end
            F_SHIFT: begin
               if (div_cnt == DIV_W'(CLK_DIV - 1)) begin
                  div_cnt <= '0;
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                     sh_rx  <= {sh_rx[FRAME_W-2:0], miso};
                  end else begin
                     sclk_q <= 1'b0;
                     if (bit_cnt == BIT_W'(FRAME_W - 1)) begin
                        cs_q <= 1'b1;
                        st   <= F_GAP;
                     end else begin
                        sh_tx   <= {sh_tx[FRAME_W-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end
               end else begin
                  div_cnt <= div_cnt + 1'b1;
               end
            end
            F_GAP: begin
               if (div_cnt == DIV_W'(2*CLK_DIV - 1)) begin
                  div_cnt <= '0;
                  done_q  <= 1'b1;
                  st      <= F_IDLE;
               end else begin
                  div_cnt <= div_cnt + 1'b1;
               end
            end
            default: st <= F_IDLE;
         endcase
      end
   end

   assign sclk    = sclk_q;
   assign cs_n    = cs_q;
   assign mosi    = sh_tx[FRAME_W-1];
   assign rx_word = sh_rx;
   assign done    = done_q;

   // R8: clock parked low while deselected
   p_sclk_low_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q |-> !sclk_q);

   // R8: data line holds while the clock is high
   p_mosi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_q && $past(sclk_q)) |-> $stable(sh_tx[FRAME_W-1]));

endmodule

// File: rtl/adc_low_pick.sv
// Lowest-index set bit of a request vector.
module adc_low_pick #(
   parameter int N = 16
) (
   input  logic [N-1:0] req,
   output logic [3:0]   idx,
   output logic [N-1:0] hot,
   output logic         any
);

   always_comb begin
      idx = '0;
      hot = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx    = i[3:0];
            hot    = '0;
            hot[i] = 1'b1;
         end
      end
   end

   assign any = |req;

endmodule

// File: rtl/adc_resp_align.sv
// Tracks which channel each in-flight frame asked for and checks answers.
module adc_resp_align
   import adc_scan_pkg::*;
#(
   parameter int SAMPLE_W = 12,
   parameter int LAT      = RESP_LAT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                push,
   input  logic                push_vld,
   input  chan_t               push_ch,
   input  logic                rsp_en,
   input  frame_t              rsp_word,
   output logic                res_valid,
   output logic [SAMPLE_W-1:0] res_data,
   output chan_t               res_chan,
   output logic                res_err
);

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("LAT must be at least 1");
      end
   endgenerate

   logic [LAT:0]        v_pipe;
   logic [LAT:0][3:0]   c_pipe;
   logic [SAMPLE_W-1:0] sample;
   chan_t               tag;

   generate
      if (SAMPLE_W == SAMPLE_MSB + 1) begin : g_full
         assign sample = rsp_word[SAMPLE_MSB:0];
      end else begin : g_part
         assign sample = rsp_word[SAMPLE_MSB -: SAMPLE_W];
      end
   endgenerate

   assign tag = rsp_word[TAG_MSB:TAG_LSB];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_pipe <= '0;
         c_pipe <= '0;
      end else if (clr) begin
         v_pipe <= '0;
         c_pipe <= '0;
      end else if (push) begin
         v_pipe <= {v_pipe[LAT-1:0], push_vld};
         c_pipe <= {c_pipe[LAT-1:0], push_ch};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
         res_chan  <= '0;
         res_err   <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         res_err   <= 1'b0;
         if (rsp_en && v_pipe[LAT]) begin
            res_valid <= 1'b1;
            res_data  <= sample;
            res_chan  <= c_pipe[LAT];
            res_err   <= (tag != c_pipe[LAT]);
         end
      end
   end

   // R6: error only reported alongside a result
   p_err_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_err |-> res_valid);

   // R5: results are single-cycle strobes
   p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_scan_pkg::*;
#(
   parameter int NUM_CH    = 16,
   parameter int SAMPLE_W  = 12,
   parameter int CLK_DIV   = 2,
   parameter bit RANGE_DBL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [NUM_CH-1:0]   ch_mask,
   output logic                busy,
   output logic                sclk,
   output logic                cs_n,
   output logic                mosi,
   input  logic                miso,
   output logic                res_valid,
   output logic [SAMPLE_W-1:0] res_data,
   output logic [3:0]          res_chan,
   output logic                res_err
);

   localparam int LAT  = RESP_LAT;
   localparam int FL_W = $clog2(LAT + 1);
   localparam int FC_W = $clog2(NUM_CH + LAT + 2);

   generate
      if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_ch
         $error("NUM_CH must lie in 1..16");
      end
      if (SAMPLE_W != 12 && SAMPLE_W != 10 && SAMPLE_W != 8) begin : g_bad_w
         $error("SAMPLE_W must be 8, 10 or 12");
      end
   endgenerate

   typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT, S_END} sstate_t;

   sstate_t          st;
   logic [NUM_CH-1:0] rem;
   logic [FL_W-1:0]  flush_cnt;
   logic [FC_W-1:0]  frm_cnt;
   frame_t           last_cmd;
   frame_t           launch_cmd;
   frame_t           rx_word;
   logic             frame_done;
   logic             go;
   logic             accept;
   logic [3:0]       pick_idx;
   logic [NUM_CH-1:0] pick_hot;
   logic             pick_any;

   adc_low_pick #(.N(NUM_CH)) u_pick (
      .req (rem),
      .idx (pick_idx),
      .hot (pick_hot),
      .any (pick_any)
   );

   assign accept     = (st == S_IDLE) && start && (|ch_mask);
   assign go         = (st == S_LAUNCH);
   assign launch_cmd = pick_any ? mk_cmd(pick_idx, RANGE_DBL) : last_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         rem       <= '0;
         flush_cnt <= '0;
         frm_cnt   <= '0;
         last_cmd  <= '0;
      end else begin
         case (st)
            S_IDLE: begin
               if (accept) begin
                  rem       <= ch_mask;
                  flush_cnt <= '0;
                  frm_cnt   <= '0;
                  st        <= S_LAUNCH;
               end
            end
            S_LAUNCH: begin
               frm_cnt <= frm_cnt + 1'b1;
               if (pick_any) begin
                  rem      <= rem & ~pick_hot;
                  last_cmd <= launch_cmd;
               end else begin
                  flush_cnt <= flush_cnt + 1'b1;
               end
               st <= S_WAIT;
            end
            S_WAIT: begin
               if (frame_done) begin
                  if (!pick_any && flush_cnt == FL_W'(LAT)) st <= S_END;
                  else                                     st <= S_LAUNCH;
               end
            end
            S_END:   st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy = (st != S_IDLE);

   adc_spi_frame #(.CLK_DIV(CLK_DIV)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .tx_word (launch_cmd),
      .rx_word (rx_word),
      .done    (frame_done),
      .sclk    (sclk),
      .cs_n    (cs_n),
      .mosi    (mosi),
      .miso    (miso)
   );

   adc_resp_align #(.SAMPLE_W(SAMPLE_W), .LAT(LAT)) u_align (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (accept),
      .push      (go),
      .push_vld  (pick_any),
      .push_ch   (pick_idx),
      .rsp_en    (frame_done),
      .rsp_word  (rx_word),
      .res_valid (res_valid),
      .res_data  (res_data),
      .res_chan  (res_chan),
      .res_err   (res_err)
   );

   // R7: results only appear inside a scan
   p_valid_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> busy);

   // R7: a scan only begins from a start request
   p_busy_from_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R3: never more frames than channels plus the flush pair
   p_frame_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (frm_cnt <= FC_W'(NUM_CH + LAT)));

endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;

   localparam int NCH = 16;
   localparam int SW  = 12;
   localparam int DIV = 2;
   localparam bit DBL = 1'b1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [NCH-1:0] ch_mask = '0;
   logic           busy, sclk, cs_n, mosi, miso;
   logic           res_valid, res_err;
   logic [SW-1:0]  res_data;
   logic [3:0]     res_chan;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   adc_scan_seq #(.NUM_CH(NCH), .SAMPLE_W(SW), .CLK_DIV(DIV), .RANGE_DBL(DBL)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .ch_mask(ch_mask), .busy(busy),
      .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
      .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan), .res_err(res_err)
   );

   // ---------------- converter model ----------------
   int          scan_seed = 0;
   bit          corrupt_en = 1'b0;
   logic [3:0]  corrupt_ch = '0;
   logic [15:0] cmd_sh = '0, hist_new = '0, hist_old = '0, out_word = '0;
   int          bit_idx = 0;
   logic [15:0] frm [0:63];
   int          frm_n = 0;

   function automatic logic [11:0] pattern(input logic [3:0] ch);
      int v;
      v = int'(ch) * 293 + scan_seed * 71 + 9;
      return v[11:0];
   endfunction

   function automatic logic [15:0] build_cmd(input logic [3:0] ch);
      logic [15:0] w;
      w = 16'h1800;
      w[10:7] = ch;
      w[6] = DBL;
      return w;
   endfunction

   function automatic logic [15:0] resp_of(input logic [15:0] c);
      logic [3:0] ch, tag;
      ch  = c[10:7];
      tag = (corrupt_en && ch == corrupt_ch) ? (ch ^ 4'h5) : ch;
      return {tag, pattern(ch)};
   endfunction

   always @(negedge cs_n) begin
      out_word = resp_of(hist_old);
      bit_idx  = 0;
   end
   always @(posedge sclk) cmd_sh = {cmd_sh[14:0], mosi};
   always @(negedge sclk) bit_idx = bit_idx + 1;
   always @(posedge cs_n) begin
      if (bit_idx == 16) begin
         hist_old = hist_new;
         hist_new = cmd_sh;
         if (frm_n < 64) frm[frm_n] = cmd_sh;
         frm_n = frm_n + 1;
      end
   end
   assign miso = (bit_idx < 16) ? out_word[15 - bit_idx] : 1'b0;

   // ---------------- monitors ----------------
   logic [3:0]    r_ch   [0:31];
   logic [SW-1:0] r_data [0:31];
   logic          r_err  [0:31];
   int r_n = 0;
   int hi_run = 0, bad_half = 0, mode_bad = 0, gap_run = 0, min_gap = 1000000;

   always @(negedge clk) begin
      if (rst_n) begin
         if (res_valid) begin
            if (r_n < 32) begin
               r_ch[r_n] = res_chan; r_data[r_n] = res_data; r_err[r_n] = res_err;
            end
            r_n = r_n + 1;
         end
         if (cs_n && sclk) mode_bad = mode_bad + 1;
         if (sclk) hi_run = hi_run + 1;
         else begin
            if (hi_run > 0 && hi_run != DIV) bad_half = bad_half + 1;
            hi_run = 0;
         end
         if (cs_n) gap_run = gap_run + 1;
         else begin
            if (gap_run > 0 && frm_n > 0 && gap_run < min_gap) min_gap = gap_run;
            gap_run = 0;
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // runs one scan; optionally fires an intruding start mid-scan
   task automatic run_scan(input logic [NCH-1:0] mask, input bit intrude,
                           input logic [NCH-1:0] other);
      logic [3:0] chs [0:15];
      int n, t, fbad, cbad, dbad, ebad;
      logic [15:0] exp_w;
      logic [SW-1:0] exp_d;
      scan_seed = scan_seed + 1;
      n = 0;
      for (int i = 0; i < NCH; i++) if (mask[i]) begin chs[n] = i[3:0]; n++; end
      @(negedge clk);
      frm_n = 0; r_n = 0;
      ch_mask = mask; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R7", "busy after start", int'(busy), 1);
      t = 0;
      while (busy && t < 20000) begin
         @(negedge clk);
         t++;
         if (intrude && t == 40) begin
            ch_mask = other; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end
      end
      repeat (3) @(negedge clk);
      chk(n == 1 ? "R9" : "R3", "frame count", frm_n, n + 2);
      fbad = 0;
      for (int i = 0; i < n + 2 && i < 64; i++) begin
         exp_w = build_cmd(chs[(i < n) ? i : n - 1]);
         if (frm[i] !== exp_w) begin
            fbad++;
            $display("  frame %0d got %h want %h", i, frm[i], exp_w);
         end
      end
      chk("R2", "command words (R4 flush repeats)", fbad, 0);
      chk("R5", "result count", r_n, n);
      cbad = 0; dbad = 0; ebad = 0;
      for (int i = 0; i < n && i < r_n; i++) begin
         exp_d = SW'(pattern(chs[i]) >> (12 - SW));
         if (r_ch[i] !== chs[i]) cbad++;
         if (r_data[i] !== exp_d) dbad++;
         if (r_err[i] !== (corrupt_en && chs[i] == corrupt_ch)) ebad++;
      end
      chk("R5", "result channel order", cbad, 0);
      chk("R5", "result data", dbad, 0);
      chk("R6", "tag error flags", ebad, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk("R1", "cs_n in reset", int'(cs_n), 1);
      chk("R1", "busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "cs_n after reset", int'(cs_n), 1);
      chk("R1", "sclk after reset", int'(sclk), 0);
      chk("R1", "busy after reset", int'(busy), 0);
      chk("R1", "res_valid after reset", int'(res_valid), 0);

      // R9 single channel
      run_scan(16'h0020, 1'b0, '0);
      // full mask
      run_scan(16'hFFFF, 1'b0, '0);
      // extreme ends
      run_scan(16'h8001, 1'b0, '0);
      // R6 corrupt tag inside a scan
      corrupt_en = 1'b1; corrupt_ch = 4'd5;
      run_scan(16'h00F8, 1'b0, '0);
      corrupt_en = 1'b0;
      // R7 zero mask ignored
      frm_n = 0;
      ch_mask = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      chk("R7", "busy on zero mask", int'(busy), 0);
      chk("R7", "frames on zero mask", frm_n, 0);
      // R7 start during busy ignored
      run_scan(16'h0C30, 1'b1, 16'h0001);

      // random scans
      for (int k = 0; k < 25; k++) begin
         logic [NCH-1:0] m;
         m = NCH'($urandom);
         if (m == '0) m = 16'h0100;
         corrupt_en = ($urandom % 4) == 0;
         corrupt_ch = 4'($urandom);
         run_scan(m, 1'b0, '0);
      end
      corrupt_en = 1'b0;

      // R8 link timing over the whole run
      chk("R8", "sclk high while deselected", mode_bad, 0);
      chk("R8", "sclk half-period errors", bad_half, 0);
      chk("R8", "min deselect gap ok", int'(min_gap >= 2 * DIV), 1);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule